// File: doc/BRIEF.md
# LNB Control Tone Transmitter

This block drives the gate of the 22 kHz tone that a satellite receiver places on the coaxial feed to steer the outdoor unit. It has three operations. It can hold a steady tone. It can send a framed command of three to six bytes. It can send a one-shot burst that selects one of two positions. The block only produces the on/off gate `toneOn`. The carrier oscillator sits outside the block.

The host loads the command bytes and starts an operation through a small register file. A single bit in the control register does two jobs: writing it as 1 starts an operation, and reading it returns 1 once the block is free for the next command. The host is expected to give up on a command if the ready bit has not returned within 200 ms.

All timing is counted in units of 0.5 ms. The parameter `UNIT_CYCLES` sets how many clock cycles make one unit.

Top module: `lnb_tone_tx`

## Requirements
- R1: After reset, `toneOn` is 0, every register reads 0 except that the control register reads 0x40 (ready), and no operation is running.
- R2: Addresses 0 to 5 hold command bytes 0 to 5. Address 6 is the control register: bit 6 is go/ready, bit 4 is steady tone enable, bit 3 selects burst B (1) or burst A (0), and bits 1:0 hold the length code. Address 7 is the mode register, where bit 2 selects burst (1) or command (0). Every bit except bit 6 reads back as written.
- R3: While no operation runs, `toneOn` equals control bit 4.
- R4: A command sends (length code + 3) bytes, starting at address 0 and going upward. Each byte goes out MSB first and is followed by an odd-parity bit, chosen so that the byte plus its parity bit hold an odd number of ones.
- R5: Every command bit takes three units. A 0 is two units of tone then one silent unit. A 1 is one unit of tone then two silent units.
- R6: Burst A is 25 units of unbroken tone. Burst B is nine 1-bits shaped as in R5.
- R7: Every command or burst is followed by 30 silent units, even when control bit 4 is set. After that the ready bit returns and `toneOn` follows control bit 4 again.
- R8: The ready bit reads 0 from the cycle after go until the silent gap ends. A control write that arrives while busy is ignored entirely. This includes a write in the last busy cycle, so no operation starts and the control value stays as it was.
- R9: The command bytes are captured when go is accepted. Writes to addresses 0 to 5 during a transmission do not change the frame being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Write address |
| wrData | input | 8 | Write data |
| rdAddr | input | 3 | Read address |
| rdData | output | 8 | Read data for `rdAddr`, combinational |
| toneOn | output | 1 | Gate of the 22 kHz carrier |

## Verification
Two events can fall in the same cycle: the end of the trailing silent gap, and a new go write from a host that is polling. The bench provokes this by issuing go in exactly the last busy cycle. It then checks three things: no new waveform appears, the ready bit reads back as 1, and the control value is unchanged. The bench also places steady tone enable, a command start, and later register writes in one sequence. This shows that the steady tone is suspended for the whole frame and gap, and comes back only in the first idle cycle.

// File: rtl/tonetx_pkg.sv
`timescale 1ns/1ps
package tonetx_pkg;
  localparam int MSG_BYTES    = 6;            // fixed by the 2-bit length code (3..6)
  localparam int BITS_PER_BYTE = 9;           // 8 data + parity
  localparam int FRAME_MAX    = MSG_BYTES * BITS_PER_BYTE;
  localparam int CNT_W        = $clog2(FRAME_MAX + 1);

  localparam logic [2:0] ADDR_CTRL = 3'd6;
  localparam logic [2:0] ADDR_MODE = 3'd7;
  localparam int BIT_GO    = 6;
  localparam int BIT_TONE  = 4;
  localparam int BIT_SEL_B = 3;
  localparam int BIT_BURST = 2;

  typedef enum logic [2:0] {PH_IDLE, PH_MSG, PH_BURSTA, PH_BURSTB, PH_GAP} phase_t;
  typedef enum logic [1:0] {K_MSG, K_BURSTA, K_BURSTB} kind_t;

  typedef struct packed {
    logic load;   // capture frame snapshot
    logic shift;  // advance to next frame bit
    logic busy;   // operation in progress
  } strobe_t;
endpackage

// File: rtl/tonetx_data.sv
`timescale 1ns/1ps
module tonetx_data
  import tonetx_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [2:0]       wrAddr,
  input  logic [7:0]       wrData,
  input  logic [2:0]       rdAddr,
  input  strobe_t          str,
  output logic [7:0]       rdData,
  output logic             startReq,
  output kind_t            startKind,
  output logic [CNT_W-1:0] frameBits,
  output logic             curBit,
  output logic             toneEnable
);
  logic [7:0] msgReg [MSG_BYTES];
  logic [7:0] ctrlReg;
  logic [7:0] modeReg;
  logic [FRAME_MAX-1:0] frame;
  logic [FRAME_MAX-1:0] frameNext;
  logic ctrlWr;

  assign ctrlWr   = wrEn && (wrAddr == ADDR_CTRL);
  assign startReq = ctrlWr && wrData[BIT_GO] && !str.busy;
  assign startKind = !modeReg[BIT_BURST] ? K_MSG :
                     (wrData[BIT_SEL_B] ? K_BURSTB : K_BURSTA);
  assign frameBits  = CNT_W'(BITS_PER_BYTE * (int'(ctrlReg[1:0]) + 3));
  assign toneEnable = ctrlReg[BIT_TONE];
  assign curBit     = frame[FRAME_MAX-1];

  for (genvar g = 0; g < MSG_BYTES; g++) begin : g_frame
    assign frameNext[FRAME_MAX-1-BITS_PER_BYTE*g -: BITS_PER_BYTE] =
      {msgReg[g], ~^msgReg[g]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MSG_BYTES; i++) msgReg[i] <= '0;
      ctrlReg <= '0;
      modeReg <= '0;
      frame   <= '0;
    end else begin
      if (wrEn) begin
        for (int i = 0; i < MSG_BYTES; i++)
          if (wrAddr == 3'(i)) msgReg[i] <= wrData;
        if (wrAddr == ADDR_MODE) modeReg <= wrData;
      end
      if (ctrlWr && !str.busy) ctrlReg <= wrData & ~(8'd1 << BIT_GO);
      if (str.load)       frame <= frameNext;
      else if (str.shift) frame <= frame << 1;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < MSG_BYTES; i++)
      if (rdAddr == 3'(i)) rdData = msgReg[i];
    if (rdAddr == ADDR_CTRL) rdData = ctrlReg | {1'b0, !str.busy, 6'b0};
    if (rdAddr == ADDR_MODE) rdData = modeReg;
  end
endmodule

// File: rtl/tonetx_ctrl.sv
`timescale 1ns/1ps
module tonetx_ctrl
  import tonetx_pkg::*;
#(
  parameter int UNIT_CYCLES   = 62500,
  parameter int BURSTA_UNITS  = 25,
  parameter int GAP_UNITS     = 30,
  parameter int BURSTB_BITS   = 9
)(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  kind_t            startKind,
  input  logic [CNT_W-1:0] frameBits,
  input  logic             curBit,
  input  logic             toneEnable,
  output strobe_t          str,
  output phase_t           phase,
  output logic [1:0]       slotUnit,
  output logic             toneOn
);
  localparam int CYC_W  = $clog2(UNIT_CYCLES + 1);
  localparam int LONG_W = $clog2(BURSTA_UNITS + GAP_UNITS + 1);

  logic [CYC_W-1:0]  cycCnt;
  logic [LONG_W-1:0] longCnt;
  logic [CNT_W-1:0]  slotCnt;
  logic [CNT_W-1:0]  lastSlot;
  logic unitEnd;

  assign unitEnd  = (cycCnt == CYC_W'(UNIT_CYCLES - 1));
  assign lastSlot = (phase == PH_MSG) ? frameBits - CNT_W'(1) : CNT_W'(BURSTB_BITS - 1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cycCnt   <= '0;
      longCnt  <= '0;
      slotCnt  <= '0;
      slotUnit <= '0;
    end else begin
      if (phase != PH_IDLE) cycCnt <= unitEnd ? '0 : cycCnt + CYC_W'(1);
      unique case (phase)
        PH_IDLE: if (startReq) begin
          cycCnt   <= '0;
          longCnt  <= '0;
          slotCnt  <= '0;
          slotUnit <= '0;
          unique case (startKind)
            K_BURSTA: phase <= PH_BURSTA;
            K_BURSTB: phase <= PH_BURSTB;
            default:  phase <= PH_MSG;
          endcase
        end
        PH_MSG, PH_BURSTB: if (unitEnd) begin
          if (slotUnit == 2'd2) begin
            slotUnit <= '0;
            if (slotCnt == lastSlot) begin
              phase   <= PH_GAP;
              longCnt <= '0;
            end else slotCnt <= slotCnt + CNT_W'(1);
          end else slotUnit <= slotUnit + 2'd1;
        end
        PH_BURSTA: if (unitEnd) begin
          if (longCnt == LONG_W'(BURSTA_UNITS - 1)) begin
            phase   <= PH_GAP;
            longCnt <= '0;
          end else longCnt <= longCnt + LONG_W'(1);
        end
        PH_GAP: if (unitEnd) begin
          if (longCnt == LONG_W'(GAP_UNITS - 1)) phase <= PH_IDLE;
          else longCnt <= longCnt + LONG_W'(1);
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    str.load  = (phase == PH_IDLE) && startReq;
    str.shift = (phase == PH_MSG) && unitEnd && (slotUnit == 2'd2);
    str.busy  = (phase != PH_IDLE);
    unique case (phase)
      PH_IDLE:   toneOn = toneEnable;
      PH_MSG:    toneOn = (slotUnit == 2'd0) || ((slotUnit == 2'd1) && !curBit);
      PH_BURSTB: toneOn = (slotUnit == 2'd0);
      PH_BURSTA: toneOn = 1'b1;
      default:   toneOn = 1'b0;
    endcase
  end
endmodule

// File: rtl/lnb_tone_tx.sv
`timescale 1ns/1ps
module lnb_tone_tx
  import tonetx_pkg::*;
#(
  parameter int UNIT_CYCLES = 62500
)(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [2:0] wrAddr,
  input  logic [7:0] wrData,
  input  logic [2:0] rdAddr,
  output logic [7:0] rdData,
  output logic       toneOn
);
  strobe_t          str;
  phase_t           phase;
  kind_t            startKind;
  logic             startReq;
  logic [CNT_W-1:0] frameBits;
  logic             curBit;
  logic             toneEnable;
  logic [1:0]       slotUnit;

  tonetx_data u_data (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .str(str), .rdData(rdData), .startReq(startReq),
    .startKind(startKind), .frameBits(frameBits), .curBit(curBit),
    .toneEnable(toneEnable)
  );

  tonetx_ctrl #(.UNIT_CYCLES(UNIT_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .startKind(startKind),
    .frameBits(frameBits), .curBit(curBit), .toneEnable(toneEnable),
    .str(str), .phase(phase), .slotUnit(slotUnit), .toneOn(toneOn)
  );
endmodule

// File: rtl/tonetx_chk.sv
`timescale 1ns/1ps
module tonetx_chk
  import tonetx_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       toneOn,
  input phase_t     phase,
  input logic [1:0] slotUnit,
  input logic       toneEnable,
  input logic       startReq,
  input logic       busy
);
  // R7
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_GAP |-> !toneOn);
  // R3
  idle_tone_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_IDLE |-> toneOn == toneEnable);
  // R6
  burst_a_chk: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_BURSTA |-> toneOn);
  // R5
  slot_tail_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((phase == PH_MSG || phase == PH_BURSTB) && slotUnit == 2'd2) |-> !toneOn);
  // R8
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    startReq |=> busy);
  // R8
  ctrl_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(toneEnable));
endmodule

bind lnb_tone_tx tonetx_chk u_chk (
  .clk(clk), .rstN(rstN), .toneOn(toneOn), .phase(phase), .slotUnit(slotUnit),
  .toneEnable(toneEnable), .startReq(startReq), .busy(str.busy)
);

// File: tb/sim_lnb_tone_tx.sv
`timescale 1ns/1ps
module sim_lnb_tone_tx;
  localparam int UNIT = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [2:0] rdAddr = 3'd6;
  logic [7:0] rdData;
  logic       toneOn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int expTone [0:255];
  int nUnits = 0;

  always #4 clk = ~clk;

  lnb_tone_tx #(.UNIT_CYCLES(UNIT)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .toneOn(toneOn)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    rdAddr = a; #1; d = rdData;
  endtask

  task automatic addUnits(input int v, input int n);
    for (int i = 0; i < n; i++) begin expTone[nUnits] = v; nUnits++; end
  endtask

  task automatic addBit(input bit b);
    addUnits(1, 1); addUnits(b ? 0 : 1, 1); addUnits(0, 1);
  endtask

  task automatic addByte(input logic [7:0] b);
    for (int k = 7; k >= 0; k--) addBit(b[k]);
    addBit(~^b);
  endtask

  // Called right after the go write, at the negedge of the first busy cycle.
  // meddle: writes a command byte and a control word mid-frame.
  // collide: issues go in the final busy cycle.
  task automatic runFrame(input string req, input bit meddle, input bit collide);
    logic [7:0] r;
    rdAddr = 3'd6;
    for (int u = 0; u < nUnits; u++) begin
      bit bad = 1'b0;
      int got = 0;
      for (int c = 0; c < UNIT; c++) begin
        #1;
        if (toneOn !== expTone[u][0]) begin bad = 1'b1; got = toneOn; end
        if (u == 1 && c == 0) begin
          r = rdData;
          chk(r[6] == 1'b0, "R8 ready low while busy", r[6], 0);
        end
        if (meddle && u == 5 && c == 0) begin wrEn = 1; wrAddr = 3'd0; wrData = 8'hFF; end
        if (meddle && u == 6 && c == 0) begin wrEn = 1; wrAddr = 3'd6; wrData = 8'h43; end
        if (collide && u == nUnits - 1 && c == UNIT - 1) begin
          wrEn = 1; wrAddr = 3'd6; wrData = 8'h40;
        end
        @(negedge clk);
        wrEn = 1'b0;
      end
      if (bad) chk(1'b0, req, got, expTone[u]);
      else     chk(1'b1, req, 0, 0);
    end
  endtask

  task automatic testReset();
    logic [7:0] r;
    chk(toneOn == 1'b0, "R1 toneOn after reset", toneOn, 0);
    rd(3'd6, r); chk(r == 8'h40, "R1 control after reset", r, 8'h40);
    rd(3'd3, r); chk(r == 8'h00, "R1 byte3 after reset", r, 0);
    rd(3'd7, r); chk(r == 8'h00, "R1 mode after reset", r, 0);
  endtask

  task automatic testRegs();
    logic [7:0] r;
    wr(3'd2, 8'h5A); wr(3'd7, 8'hA4); wr(3'd6, 8'h1B);
    rd(3'd2, r); chk(r == 8'h5A, "R2 byte readback", r, 8'h5A);
    rd(3'd7, r); chk(r == 8'hA4, "R2 mode readback", r, 8'hA4);
    rd(3'd6, r); chk(r == 8'h5B, "R2 control readback", r, 8'h5B);
    chk(toneOn == 1'b1, "R3 steady tone on", toneOn, 1);
    wr(3'd6, 8'h00); #1;
    chk(toneOn == 1'b0, "R3 steady tone off", toneOn, 0);
    wr(3'd7, 8'h00);
  endtask

  task automatic testMsg3();
    logic [7:0] r;
    wr(3'd0, 8'hE0); wr(3'd1, 8'h10); wr(3'd2, 8'h00);
    nUnits = 0;
    addByte(8'hE0); addByte(8'h10); addByte(8'h00); addUnits(0, 30);
    wr(3'd6, 8'h50);
    runFrame("R4 R5 R7 three-byte frame, tone suspended", 1'b0, 1'b0);
    #1;
    chk(toneOn == 1'b1, "R7 steady tone restored", toneOn, 1);
    rd(3'd6, r); chk(r == 8'h50, "R7 ready returned", r, 8'h50);
    wr(3'd6, 8'h00);
  endtask

  task automatic testMsg6();
    logic [7:0] r;
    logic [7:0] bytes [6] = '{8'h81, 8'h3C, 8'h7F, 8'hA5, 8'h01, 8'hFE};
    for (int i = 0; i < 6; i++) wr(3'(i), bytes[i]);
    nUnits = 0;
    for (int i = 0; i < 6; i++) addByte(bytes[i]);
    addUnits(0, 30);
    wr(3'd6, 8'h43);
    runFrame("R4 R9 six-byte frame with writes while busy", 1'b1, 1'b0);
    rd(3'd6, r); chk(r == 8'h43, "R8 control unchanged by busy write", r, 8'h43);
    rd(3'd0, r); chk(r == 8'hFF, "R9 byte write while busy stored", r, 8'hFF);
  endtask

  task automatic testMsg4();
    logic [7:0] bytes [4] = '{8'hA5, 8'h00, 8'hFF, 8'h3C};
    for (int i = 0; i < 4; i++) wr(3'(i), bytes[i]);
    nUnits = 0;
    for (int i = 0; i < 4; i++) addByte(bytes[i]);
    addUnits(0, 30);
    wr(3'd6, 8'h41);
    runFrame("R4 R5 four-byte frame", 1'b0, 1'b0);
  endtask

  task automatic testBurstA();
    wr(3'd7, 8'h04);
    nUnits = 0; addUnits(1, 25); addUnits(0, 30);
    wr(3'd6, 8'h50);
    runFrame("R6 R7 burst A", 1'b0, 1'b0);
    #1; chk(toneOn == 1'b1, "R7 tone back after burst A", toneOn, 1);
  endtask

  task automatic testBurstB();
    logic [7:0] r;
    bit seen = 1'b0;
    nUnits = 0;
    for (int i = 0; i < 9; i++) addBit(1'b1);
    addUnits(0, 30);
    wr(3'd6, 8'h48);
    runFrame("R6 burst B", 1'b0, 1'b1);
    for (int i = 0; i < 3 * UNIT; i++) begin #1; if (toneOn) seen = 1'b1; @(negedge clk); end
    chk(!seen, "R8 go in last busy cycle dropped (tone)", seen, 0);
    rd(3'd6, r); chk(r == 8'h48, "R8 go in last busy cycle dropped (ready)", r, 8'h48);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testRegs();
    testMsg3();
    testMsg6();
    testMsg4();
    testBurstA();
    testBurstB();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule